// File: doc/BRIEF.md
# Hierarchical Eight-Way Pseudo-LRU Replacement Keeper

This block holds the replacement state for an eight-way set-associative cache. Each set keeps ten bits. Six of them order the four way pairs by recency, as the lower triangle of a 4x4 recency matrix. The other four record which way inside each pair was used less recently. Tag storage, hit detection and the data arrays live elsewhere.

Two hit ports report accesses. Each port carries a valid flag, a set index and a way number. Both ports may name the same set in one cycle, and the result is then defined by port order. A lookup port takes a set index and returns, combinationally, the way that should be replaced next and the raw ten-bit state of that set. The lookup shows the state registered at the last clock edge, so hits made in the same cycle do not appear until the following cycle.

Top module: `plru8_keeper`

## Requirements
- R1: `lk_state` packs a set's state as follows. Bit 0 is M30, bit 1 is M31, bit 2 is M32, bit 3 is M20, bit 4 is M21 and bit 5 is M10. Each bit Mik (i>k) is 1 when pair i was used more recently than pair k. Bits 6+n hold the pair bit of pair n, for n from 0 to 3.
- R2: A synchronous reset loads every set with 10'h029, which makes way 0 the victim.
- R3: A hit on way j marks pair m = j/2 as the most recent. Stored bits Mmk with k<m become 1, stored bits Mim with i>m become 0, and the other matrix bits are kept.
- R4: A hit on way j writes the inverse of (j mod 2) into the pair bit of pair j/2. The other pair bits are kept.
- R5: A set named by no valid hit keeps its state. A hit port whose valid flag is low has no effect.
- R6: The victim way is 2*p+q. Here p is the pair that is older than every other pair, and q is the pair bit of p.
- R7: Exactly one pair qualifies as oldest in every set at all times.
- R8: When both ports hit the same set in one cycle, the result equals applying port 0 and then port 1.
- R9: When the ports hit different sets in one cycle, both updates take effect.
- R10: The lookup outputs reflect the state at the last clock edge. A hit in the current cycle is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| u0_vld | input | 1 | Hit port 0 valid |
| u0_set | input | SW | Hit port 0 set index |
| u0_way | input | 3 | Hit port 0 way |
| u1_vld | input | 1 | Hit port 1 valid |
| u1_set | input | SW | Hit port 1 set index |
| u1_way | input | 3 | Hit port 1 way |
| lk_set | input | SW | Lookup set index |
| lk_way | output | 3 | Way to replace in the looked-up set |
| lk_state | output | 10 | Raw state of the looked-up set |

## Verification
The bench builds the block with SETS=4. This is small enough that every set can be read back after every hit, which shows that no other set was disturbed. In that configuration the bench tries every way on every set for each port alone. It tries all 64 way pairs with both ports on one set, and many cross-set pairs. The bench models the state as a per-set recency ranking of the pairs, so the expected matrix bits come from comparing ranks and not from the update rules.

// File: rtl/plru8_keeper.sv
module plru8_keeper #(
  parameter int SETS = 16,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          u0_vld,
  input  logic [SW-1:0] u0_set,
  input  logic [2:0]    u0_way,
  input  logic          u1_vld,
  input  logic [SW-1:0] u1_set,
  input  logic [2:0]    u1_way,
  input  logic [SW-1:0] lk_set,
  output logic [2:0]    lk_way,
  output logic [9:0]    lk_state
);
  localparam logic [9:0] INIT = 10'h029;

  logic [9:0] mem [SETS];
  logic [9:0] nxt [SETS];

  function automatic logic [9:0] touch(input logic [9:0] st, input logic [2:0] w);
    logic [9:0] n;
    n = st;
    case (w[2:1])
      2'd0: begin n[0] = 1'b0; n[3] = 1'b0; n[5] = 1'b0; end
      2'd1: begin n[5] = 1'b1; n[1] = 1'b0; n[4] = 1'b0; end
      2'd2: begin n[3] = 1'b1; n[4] = 1'b1; n[2] = 1'b0; end
      default: begin n[0] = 1'b1; n[1] = 1'b1; n[2] = 1'b1; end
    endcase
    n[6 + int'(w[2:1])] = ~w[0];
    return n;
  endfunction

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      nxt[s] = mem[s];
      if (u0_vld && u0_set == SW'(s)) nxt[s] = touch(nxt[s], u0_way);
      if (u1_vld && u1_set == SW'(s)) nxt[s] = touch(nxt[s], u1_way);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++)
      mem[s] <= rst ? INIT : nxt[s];
  end

  assign lk_state = mem[lk_set];

  logic [3:0] oldest;
  logic [1:0] pv;
  assign oldest[0] =  lk_state[5] &  lk_state[3] &  lk_state[0];
  assign oldest[1] = ~lk_state[5] &  lk_state[4] &  lk_state[1];
  assign oldest[2] = ~lk_state[3] & ~lk_state[4] &  lk_state[2];
  assign oldest[3] = ~lk_state[0] & ~lk_state[1] & ~lk_state[2];

  always_comb begin
    pv = 2'd0;
    for (int e = 0; e < 4; e++)
      if (oldest[e]) pv = 2'(e);
  end

  assign lk_way = {pv, lk_state[6 + int'(pv)]};
endmodule

// File: rtl/plru8_keeper_chk.sv
module plru8_keeper_chk #(
  parameter int SETS = 16,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          u0_vld,
  input logic [SW-1:0] u0_set,
  input logic [2:0]    u0_way,
  input logic          u1_vld,
  input logic [SW-1:0] u1_set,
  input logic [2:0]    u1_way,
  input logic [SW-1:0] lk_set,
  input logic [2:0]    lk_way,
  input logic [9:0]    lk_state
);
  logic [3:0] old_p;
  assign old_p[0] =  lk_state[5] &  lk_state[3] &  lk_state[0];
  assign old_p[1] = ~lk_state[5] &  lk_state[4] &  lk_state[1];
  assign old_p[2] = ~lk_state[3] & ~lk_state[4] &  lk_state[2];
  assign old_p[3] = ~lk_state[0] & ~lk_state[1] & ~lk_state[2];

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (lk_state == 10'h029 && lk_way == 3'd0));

  a_r7_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(old_p) == 1);

  a_r3_hit0_not_victim: assert property (@(posedge clk) disable iff (rst)
    (u0_vld && !u1_vld) |=> (lk_set != $past(u0_set) || lk_way != $past(u0_way)));

  a_r3_hit1_not_victim: assert property (@(posedge clk) disable iff (rst)
    (u1_vld && !u0_vld) |=> (lk_set != $past(u1_set) || lk_way != $past(u1_way)));

  a_r8_port1_pair_newest: assert property (@(posedge clk) disable iff (rst)
    (u0_vld && u1_vld && u0_set == u1_set) |=>
      (lk_set != $past(u1_set) || lk_way[2:1] != $past(u1_way[2:1])));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!u0_vld && !u1_vld) |=> (lk_set != $past(lk_set) || $stable(lk_state)));
endmodule

bind plru8_keeper plru8_keeper_chk #(.SETS(SETS)) u_chk (.*);

// File: tb/tb_plru8_keeper.sv
module tb_plru8_keeper;
  localparam int PERIOD = 10;
  localparam int SETS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic u0_vld = 1'b0, u1_vld = 1'b0;
  logic [SW-1:0] u0_set = '0, u1_set = '0, lk_set = '0;
  logic [2:0] u0_way = '0, u1_way = '0;
  logic [2:0] lk_way;
  logic [9:0] lk_state;

  plru8_keeper #(.SETS(SETS)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int rk [SETS][4];
  logic pb [SETS][4];
  int tick;

  function automatic logic [9:0] exp_state(int s);
    logic [9:0] e;
    e[0] = rk[s][3] > rk[s][0];
    e[1] = rk[s][3] > rk[s][1];
    e[2] = rk[s][3] > rk[s][2];
    e[3] = rk[s][2] > rk[s][0];
    e[4] = rk[s][2] > rk[s][1];
    e[5] = rk[s][1] > rk[s][0];
    for (int n = 0; n < 4; n++) e[6+n] = pb[s][n];
    return e;
  endfunction

  function automatic logic [2:0] exp_way(int s);
    int p = 0;
    for (int n = 1; n < 4; n++) if (rk[s][n] < rk[s][p]) p = n;
    return {2'(p), pb[s][p]};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      rk[s][0] = 0; rk[s][3] = 1; rk[s][2] = 2; rk[s][1] = 3;
      for (int n = 0; n < 4; n++) pb[s][n] = 1'b0;
    end
    tick = 4;
  endtask

  task automatic model_hit(int s, logic [2:0] w);
    rk[s][w[2:1]] = tick++;
    pb[s][w[2:1]] = ~w[0];
  endtask

  task automatic cmp(string req, logic [9:0] act, logic [9:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < SETS; s++) begin
      lk_set = SW'(s);
      #1;
      cmp({req, " R1 state"}, lk_state, exp_state(s));
      cmp("R6/R7 victim", {7'd0, lk_way}, {7'd0, exp_way(s)});
    end
  endtask

  task automatic hit(logic v0, int s0, logic [2:0] w0, logic v1, int s1, logic [2:0] w1, string req);
    @(negedge clk);
    u0_vld = v0; u0_set = SW'(s0); u0_way = w0;
    u1_vld = v1; u1_set = SW'(s1); u1_way = w1;
    lk_set = SW'(s0);
    #1;
    cmp("R10 no forwarding", lk_state, exp_state(s0));
    @(posedge clk);
    if (v0) model_hit(s0, w0);
    if (v1) model_hit(s1, w1);
    #1;
    u0_vld = 1'b0; u1_vld = 1'b0;
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    u0_vld = 1'b1; u1_vld = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    u0_vld = 1'b0; u1_vld = 1'b0;
    model_reset();
    check_all("R2 reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();
    // R3 R4 R5: single hits on port 0, every set and every way
    for (int s = 0; s < SETS; s++)
      for (int j = 0; j < 8; j++)
        hit(1'b1, s, 3'(j), 1'b0, 0, 3'd0, "R3 R4 R5 port0");
    // R3 R4: single hits on port 1, reverse order
    for (int s = SETS-1; s >= 0; s--)
      for (int j = 7; j >= 0; j--)
        hit(1'b0, 0, 3'd0, 1'b1, s, 3'(j), "R3 R4 R5 port1");
    // R5: idle cycles and disabled ports with live set/way values
    for (int k = 0; k < 4; k++)
      hit(1'b0, k, 3'(k+3), 1'b0, 3-k, 3'(k), "R5 idle");
    // R8: both ports on one set, every way pair
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        hit(1'b1, 1, 3'(a), 1'b1, 1, 3'(b), "R8 same set");
    // R9: ports on different sets
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        hit(1'b1, a % SETS, 3'(a), 1'b1, (a + 1 + b % 3) % SETS, 3'(b), "R9 cross set");
    // R2: reset in the middle of activity
    do_reset();
    hit(1'b1, 2, 3'd5, 1'b1, 2, 3'd4, "R8 after reset");
    finish_run();
  end
endmodule